// File: doc/BRIEF.md
# Debug Event Selector and Qualification Flag

This block collects a fixed 32-position vector of local debug events inside a serial memory-buffer link controller and routes chosen positions to debug outputs. The vector holds the current link initialization state, the incoming shared event-bus lanes, a qualification flag, and a set of error conditions that software can mask. Position 0 is a null event and position 31 is a spare. Both always read as zero.

Nineteen selector registers, each holding a 5-bit event position, are loaded through a small address/data/write-enable port. Eleven of them drive trace trigger lines and four drive the outgoing event-bus lanes. One drives a northbound inject-event line and one drives an error-injection trigger. The last two name the start and stop events of a qualification flag. Every selected output is registered. After reset, every selector points at the null event, so nothing fires until software programs it.

One error condition is a clock-training check. While the link is in its training state, the block counts level changes on a sampled training line over fixed windows. It flags a window that holds too few changes.

Top module: `dbg_event_router`

## Requirements
- R1: Event positions 0 and 31 never assert. After reset every selector holds 0, so every trigger, lane, inject and qualification output is low.
- R2: Link state code k (0 disable, 1 calibrate, 2 training, 3 testing, 4 polling, 5 config, 6 L0, 7 L0s-or-recalibrate) asserts event position k+1, and exactly one of positions 1..8 is high.
- R3: Event positions 9..12 carry incoming event-bus lanes 0..3, and positions 13..23 always read zero.
- R4: Event positions 25..30 are fail-over, southbound CRC error, thermal overload, clock-training violation, unimplemented register access and other errors. Position 25+i is forced low while bit i of the mask register (address 19, write data bits 5:0) is set.
- R5: Position 30 is high when any of the 4 upper-field bits of the first-error register or of the next-error register is set.
- R6: While the link state is training (code 2), the cycles from entry form windows of WIN_UI cycles. Position 28 is high for one cycle, on the window's last cycle, when fewer than MIN_TRANS changes of the training line fell in that window. Outside training it stays low.
- R7: The qualification flag sets on the cycle after its selected start event is high. It holds while neither start nor stop is high, and start wins when both are high.
- R8: The qualification flag clears on the cycle after its selected stop event is high without the start event. Position 24 reflects the flag.
- R9: The selector addresses are 0..10 for trigger lines 0..10, 11..14 for event-bus lanes 0..3, 15 for the inject-event line, 16 for the error-injection trigger, 17 for qualification start and 18 for qualification stop. The position is written in bits 4:0, and every output follows only its own selector.
- R10: Each trigger, lane and inject output is registered: it shows the selected event as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Selector/mask write strobe |
| cfg_addr | input | 5 | Selector/mask address |
| cfg_wdata | input | 6 | Write data |
| link_state_i | input | 3 | Current link initialization state code |
| train_line_i | input | 1 | Sampled training line, one sample per unit interval |
| failover_i | input | 1 | Fail-over mode active |
| crc_err_i | input | 1 | Southbound CRC error strobe |
| thermal_i | input | 1 | Thermal overload strobe |
| unimpl_i | input | 1 | Unimplemented register access strobe |
| ferr_hi_i | input | 4 | Upper field of first-error register |
| nerr_hi_i | input | 4 | Upper field of next-error register |
| evbus_i | input | 4 | Incoming shared event-bus lanes |
| trig_o | output | 11 | Trace trigger lines |
| evbus_o | output | 4 | Outgoing shared event-bus lanes |
| nb_inject_o | output | 1 | Northbound inject-event line |
| err_inject_o | output | 1 | Error-injection trigger |
| qual_o | output | 1 | Qualification flag |

## Verification
The bench builds the block with WIN_UI = 16 and MIN_TRANS = 6. With the short window, several complete training windows fit into a few dozen cycles, so the bench can count violation pulses across window boundaries. It also exercises the threshold on both sides, with five changes against six in one window. The other parameters stay at their defaults, which are fixed by the 32-position event space.

// File: rtl/dbg_evt_pkg.sv
// Package: shared sizes, selector address map and event positions.
// Assumes a 32-position event space, so each position fits in 5 bits.
package dbg_evt_pkg;
    localparam int EVT_N      = 32;
    localparam int IDX_W      = $clog2(EVT_N);
    localparam int N_TRIG     = 11;
    localparam int N_LANE     = 4;
    localparam int N_ERR      = 6;
    localparam int N_STATE    = 8;
    localparam int N_SEL      = N_TRIG + N_LANE + 4;
    localparam int N_OUT      = N_SEL - 2;
    localparam int ADDR_W     = 5;
    localparam int CFG_DW     = (N_ERR > IDX_W) ? N_ERR : IDX_W;
    localparam int ERR_FLD_W  = 4;

    // selector address map
    localparam int SEL_LANE0  = N_TRIG;
    localparam int SEL_NBINJ  = N_TRIG + N_LANE;
    localparam int SEL_ERRINJ = SEL_NBINJ + 1;
    localparam int SEL_QSTART = SEL_NBINJ + 2;
    localparam int SEL_QSTOP  = SEL_NBINJ + 3;
    localparam int ADDR_MASK  = N_SEL;

    // event positions
    localparam int EV_STATE0  = 1;
    localparam int EV_LANEIN0 = 9;
    localparam int EV_QUAL    = 24;
    localparam int EV_ERR0    = 25;

    typedef enum logic [2:0] {
        LS_DISABLE, LS_CALIB, LS_TRAIN, LS_TEST,
        LS_POLL, LS_CONFIG, LS_L0, LS_L0S_RECAL
    } link_state_e;

    typedef logic [IDX_W-1:0] evt_idx_t;
endpackage

// File: rtl/dbg_cfg_regs.sv
// Selector and mask registers written through an address/data port.
// Assumes addresses past the mask register are ignored.
module dbg_cfg_regs
    import dbg_evt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [CFG_DW-1:0]       cfg_wdata,
    output evt_idx_t                sel_all [N_SEL],
    output logic [N_ERR-1:0]        err_mask
);
    // Load the selector addressed by the write port.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_SEL; i++) begin
            if (!rst_n)
                sel_all[i] <= '0;
            else if (cfg_we && cfg_addr == ADDR_W'(i))
                sel_all[i] <= cfg_wdata[IDX_W-1:0];
        end
    end

    // Load the error mask when its address is written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_mask <= '0;
        else if (cfg_we && cfg_addr == ADDR_W'(ADDR_MASK))
            err_mask <= cfg_wdata[N_ERR-1:0];
    end
endmodule

// File: rtl/dbg_train_mon.sv
// Clock-training monitor: counts changes of the sampled line over fixed
// windows of WIN_UI cycles and pulses viol_o on the last cycle of a window
// with fewer than MIN_TRANS changes. Windows restart whenever active drops.
module dbg_train_mon #(
    parameter int WIN_UI    = 512,
    parameter int MIN_TRANS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic line_i,
    output logic viol_o
);
    localparam int CNT_W = $clog2(WIN_UI);
    localparam int TR_W  = $clog2(MIN_TRANS + 1);

    logic             line_q;
    logic [CNT_W-1:0] ui_cnt;
    logic [TR_W-1:0]  tr_cnt;
    logic [TR_W-1:0]  tr_next;
    logic             chg;

    // Remember the previous line sample to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_i;
    end

    // Saturating change count including this cycle.
    always_comb begin
        chg     = line_i ^ line_q;
        tr_next = (tr_cnt == TR_W'(MIN_TRANS)) ? tr_cnt : tr_cnt + TR_W'(chg);
    end

    // Advance the window and flag a sparse one at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            ui_cnt <= '0;
            tr_cnt <= '0;
            viol_o <= 1'b0;
        end else if (ui_cnt == CNT_W'(WIN_UI - 1)) begin
            ui_cnt <= '0;
            tr_cnt <= '0;
            viol_o <= (tr_next < TR_W'(MIN_TRANS));
        end else begin
            ui_cnt <= ui_cnt + 1'b1;
            tr_cnt <= tr_next;
            viol_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_evt_vector.sv
// Builds the 32-position event vector from state, lanes, flag and errors.
// Purely combinational; positions not listed stay zero.
module dbg_evt_vector
    import dbg_evt_pkg::*;
(
    input  logic [2:0]           link_state,
    input  logic [N_LANE-1:0]    lanes_in,
    input  logic                 qual_q,
    input  logic                 failover,
    input  logic                 crc_err,
    input  logic                 thermal,
    input  logic                 train_viol,
    input  logic                 unimpl,
    input  logic [ERR_FLD_W-1:0] ferr_hi,
    input  logic [ERR_FLD_W-1:0] nerr_hi,
    input  logic [N_ERR-1:0]     err_mask,
    output logic [EVT_N-1:0]     evt_vec
);
    logic [N_ERR-1:0] raw_err;

    // Assemble every event position.
    always_comb begin
        raw_err = {(|ferr_hi) | (|nerr_hi), unimpl, train_viol, thermal, crc_err, failover};
        evt_vec = '0;
        for (int i = 0; i < N_STATE; i++)
            evt_vec[EV_STATE0 + i] = (link_state == 3'(i));
        evt_vec[EV_LANEIN0 +: N_LANE] = lanes_in;
        evt_vec[EV_QUAL]              = qual_q;
        evt_vec[EV_ERR0 +: N_ERR]     = raw_err & ~err_mask;
    end
endmodule

// File: rtl/dbg_sel_out.sv
// One multiplexer per output selector, followed by one register stage.
module dbg_sel_out
    import dbg_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_vec,
    input  evt_idx_t         sel_all [N_SEL],
    output logic [N_OUT-1:0] out_q
);
    logic [N_OUT-1:0] pick;

    for (genvar g = 0; g < N_OUT; g++) begin : g_mux
        assign pick[g] = evt_vec[sel_all[g]];
    end

    // Register the selected events.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= pick;
    end
endmodule

// File: rtl/dbg_event_router.sv
// Top: debug event selector with qualification flag.
// Assumes all inputs are synchronous to clk.
module dbg_event_router
    import dbg_evt_pkg::*;
#(
    parameter int WIN_UI    = 512,
    parameter int MIN_TRANS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [4:0]           cfg_addr,
    input  logic [5:0]           cfg_wdata,
    input  logic [2:0]           link_state_i,
    input  logic                 train_line_i,
    input  logic                 failover_i,
    input  logic                 crc_err_i,
    input  logic                 thermal_i,
    input  logic                 unimpl_i,
    input  logic [3:0]           ferr_hi_i,
    input  logic [3:0]           nerr_hi_i,
    input  logic [3:0]           evbus_i,
    output logic [10:0]          trig_o,
    output logic [3:0]           evbus_o,
    output logic                 nb_inject_o,
    output logic                 err_inject_o,
    output logic                 qual_o
);
    evt_idx_t         sel_all [N_SEL];
    logic [N_ERR-1:0] err_mask;
    logic [EVT_N-1:0] evt_vec;
    logic [N_OUT-1:0] out_q;
    logic             train_viol;
    logic             qual_q;
    logic             q_start;
    logic             q_stop;

    dbg_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sel_all(sel_all), .err_mask(err_mask)
    );

    dbg_train_mon #(.WIN_UI(WIN_UI), .MIN_TRANS(MIN_TRANS)) u_train (
        .clk(clk), .rst_n(rst_n),
        .active(link_state_i == LS_TRAIN),
        .line_i(train_line_i), .viol_o(train_viol)
    );

    dbg_evt_vector u_vec (
        .link_state(link_state_i), .lanes_in(evbus_i), .qual_q(qual_q),
        .failover(failover_i), .crc_err(crc_err_i), .thermal(thermal_i),
        .train_viol(train_viol), .unimpl(unimpl_i), .ferr_hi(ferr_hi_i),
        .nerr_hi(nerr_hi_i), .err_mask(err_mask), .evt_vec(evt_vec)
    );

    dbg_sel_out u_out (
        .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec),
        .sel_all(sel_all), .out_q(out_q)
    );

    // Pick the start and stop events of the qualification window.
    always_comb begin
        q_start = evt_vec[sel_all[SEL_QSTART]];
        q_stop  = evt_vec[sel_all[SEL_QSTOP]];
    end

    // Qualification flag: start sets, stop clears, start wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       qual_q <= 1'b0;
        else if (q_start) qual_q <= 1'b1;
        else if (q_stop)  qual_q <= 1'b0;
    end

    assign trig_o       = out_q[N_TRIG-1:0];
    assign evbus_o      = out_q[SEL_LANE0 +: N_LANE];
    assign nb_inject_o  = out_q[SEL_NBINJ];
    assign err_inject_o = out_q[SEL_ERRINJ];
    assign qual_o       = qual_q;
endmodule

// File: rtl/dbg_event_router_chk.sv
// Checker bound to the top: temporal properties of the event router.
module dbg_event_router_chk
    import dbg_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [EVT_N-1:0] evt_vec,
    input evt_idx_t         sel_trig0,
    input evt_idx_t         sel_qstart,
    input evt_idx_t         sel_qstop,
    input logic [N_ERR-1:0] err_mask,
    input logic [10:0]      trig_o,
    input logic             qual_o
);
    AST_NULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (sel_trig0 == '0) |=> !trig_o[0]); // R1
    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(evt_vec[8:1]) == 1); // R2
    AST_MASK_CRC: assert property (@(posedge clk) disable iff (!rst_n) err_mask[1] |-> !evt_vec[26]); // R4
    AST_QUAL_SET: assert property (@(posedge clk) disable iff (!rst_n) evt_vec[sel_qstart] |=> qual_o); // R7
    AST_QUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!evt_vec[sel_qstart] && !evt_vec[sel_qstop]) |=> $stable(qual_o)); // R7
    AST_QUAL_CLR: assert property (@(posedge clk) disable iff (!rst_n) (evt_vec[sel_qstop] && !evt_vec[sel_qstart]) |=> !qual_o); // R8
    AST_TRIG_REG: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (trig_o[0] == $past(evt_vec[sel_trig0]))); // R10
endmodule

bind dbg_event_router dbg_event_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec),
    .sel_trig0(sel_all[0]),
    .sel_qstart(sel_all[dbg_evt_pkg::SEL_QSTART]),
    .sel_qstop(sel_all[dbg_evt_pkg::SEL_QSTOP]),
    .err_mask(err_mask), .trig_o(trig_o), .qual_o(qual_o)
);

// File: tb/sim_dbg_event_router.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_dbg_event_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [5:0]  cfg_wdata = '0;
    logic [2:0]  link_state_i = 3'd6;
    logic        train_line_i = 1'b0;
    logic        failover_i = 1'b0, crc_err_i = 1'b0, thermal_i = 1'b0, unimpl_i = 1'b0;
    logic [3:0]  ferr_hi_i = '0, nerr_hi_i = '0, evbus_i = '0;
    logic [10:0] trig_o;
    logic [3:0]  evbus_o;
    logic        nb_inject_o, err_inject_o, qual_o;
    int          n_chk = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    dbg_event_router #(.WIN_UI(16), .MIN_TRANS(6)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int addr, input int data);
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = 6'(data);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic clear_inputs();
        failover_i = 0; crc_err_i = 0; thermal_i = 0; unimpl_i = 0;
        ferr_hi_i = 0; nerr_hi_i = 0; evbus_i = 0;
    endtask

    // R1: all outputs low after reset, even with events active
    task automatic t_reset();
        failover_i = 1; evbus_i = 4'hF;
        step(); step();
        check("R1 trig after reset", 32'(trig_o), 0);
        check("R1 lanes after reset", 32'(evbus_o), 0);
        check("R1 inject/qual after reset", {29'd0, nb_inject_o, err_inject_o, qual_o}, 0);
        clear_inputs();
    endtask

    // R2 state map and R10 register latency
    task automatic t_states();
        for (int k = 0; k < 8; k++) wr(k, k + 1);
        link_state_i = 3'd0;
        step();
        check("R2 state 0", 32'(trig_o[7:0]), 1);
        for (int c = 1; c < 8; c++) begin
            link_state_i = 3'(c);
            #1;
            check("R10 before edge", 32'(trig_o[7:0]), 32'(1) << (c - 1));
            step();
            check("R2 state code", 32'(trig_o[7:0]), 32'(1) << c);
        end
        link_state_i = 3'd6;
    endtask

    // R1 null and spare positions with every input high
    task automatic t_null_spare();
        wr(0, 0); wr(1, 31); wr(2, 13); wr(3, 23);
        failover_i = 1; crc_err_i = 1; thermal_i = 1; unimpl_i = 1;
        ferr_hi_i = 4'hF; nerr_hi_i = 4'hF; evbus_i = 4'hF;
        step();
        check("R1 null/spare", 32'(trig_o[1:0]), 0);
        check("R3 unused positions", 32'(trig_o[3:2]), 0);
        clear_inputs();
    endtask

    // R3 and R9: lane i out carries lane 3-i in
    task automatic t_lanes();
        for (int i = 0; i < 4; i++) wr(11 + i, 9 + (3 - i));
        evbus_i = 4'b0001; step();
        check("R3 lane swap a", 32'(evbus_o), 32'b1000);
        evbus_i = 4'b0110; step();
        check("R3 lane swap b", 32'(evbus_o), 32'b0110);
        evbus_i = 4'b1011; step();
        check("R9 lanes independent", 32'(evbus_o), 32'b1101);
        clear_inputs(); step();
    endtask

    // R4 mask and R5 error-field OR
    task automatic t_errors();
        for (int k = 0; k < 6; k++) wr(k, 25 + k);
        failover_i = 1; step();
        check("R4 failover", 32'(trig_o[5:0]), 32'h01); failover_i = 0;
        crc_err_i = 1; step();
        check("R4 crc", 32'(trig_o[5:0]), 32'h02); crc_err_i = 0;
        thermal_i = 1; step();
        check("R4 thermal", 32'(trig_o[5:0]), 32'h04); thermal_i = 0;
        unimpl_i = 1; step();
        check("R4 unimpl", 32'(trig_o[5:0]), 32'h10); unimpl_i = 0;
        ferr_hi_i = 4'b0001; step();
        check("R5 ferr field", 32'(trig_o[5:0]), 32'h20); ferr_hi_i = 0;
        nerr_hi_i = 4'b1000; step();
        check("R5 nerr field", 32'(trig_o[5:0]), 32'h20); nerr_hi_i = 0;
        wr(19, 6'h3F);
        failover_i = 1; crc_err_i = 1; thermal_i = 1; unimpl_i = 1; ferr_hi_i = 4'hF;
        step();
        check("R4 all masked", 32'(trig_o[5:0]), 0);
        wr(19, 6'b000010);
        step();
        check("R4 crc masked only", 32'(trig_o[5:0]), 32'h35);
        wr(19, 0);
        clear_inputs(); step();
    endtask

    // R7/R8 qualification flag; start = crc (26), stop = thermal (27)
    task automatic t_qual();
        wr(17, 26); wr(18, 27); wr(6, 24);
        check("R7 flag idle", 32'(qual_o), 0);
        crc_err_i = 1; step();
        check("R7 set after start", 32'(qual_o), 1);
        crc_err_i = 0; step();
        check("R7 holds", 32'(qual_o), 1);
        check("R8 position 24 follows flag", 32'(trig_o[6]), 1);
        thermal_i = 1; step();
        check("R8 clear after stop", 32'(qual_o), 0);
        crc_err_i = 1; step();
        check("R7 start wins", 32'(qual_o), 1);
        crc_err_i = 0; step();
        check("R8 stop alone clears", 32'(qual_o), 0);
        thermal_i = 0; step();
        check("R8 position 24 low", 32'(trig_o[6]), 0);
    endtask

    // R9 inject and error-injection selectors
    task automatic t_inject();
        wr(15, 26); wr(16, 27);
        crc_err_i = 1; step();
        check("R9 inject on crc", {30'd0, nb_inject_o, err_inject_o}, 32'b10);
        crc_err_i = 0; thermal_i = 1; step();
        check("R9 errinj on thermal", {30'd0, nb_inject_o, err_inject_o}, 32'b01);
        thermal_i = 0; step();
    endtask

    // R6 training-window violation count over 36 cycles
    task automatic run_train(input int k, input int exp, input logic train);
        int pulses = 0;
        link_state_i = 3'd6; train_line_i = 0; step(); step();
        link_state_i = train ? 3'd2 : 3'd4;
        for (int c = 0; c < 36; c++) begin
            train_line_i = logic'(((c + 1) < k ? (c + 1) : k) % 2);
            step();
            if (trig_o[7]) pulses++;
        end
        check(train ? "R6 window pulses" : "R6 quiet outside training", 32'(pulses), 32'(exp));
        link_state_i = 3'd6;
    endtask

    task automatic t_train();
        wr(7, 28);
        run_train(5, 2, 1'b1);
        run_train(6, 1, 1'b1);
        run_train(0, 0, 1'b0);
    endtask

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        t_reset();
        t_states();
        t_null_spare();
        t_lanes();
        t_errors();
        t_qual();
        t_inject();
        t_train();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule